// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block is the raster counter of a display pipe. A horizontal pixel counter and a vertical line counter run from programmed totals. Compare logic turns the two positions into sync pulses, blank flags and a data-enable. Position zero on each axis is the leading edge of sync, not the first active pixel. Blank start and blank end are therefore absolute counter values: the first active position is the sync width plus the back porch, and blank starts again after the left border, the addressable region and the right border.

Software programs the block through a single-cycle register write port. Timing values and sync or interlace options are staged in pending registers and copied into the active set at the next frame wrap, so a frame never uses a mix of old and new timing. While the block is stopped, staged values are copied one cycle after the write.

Forced blanking replaces the incoming pixel with a stored blank colour. Status outputs report the position, vertical blank, a frame count and an interlace field flag. The pixel path is paced by the raster and has no flow control.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset both positions, the frame count and the field flag are 0 and the block is stopped. While running, the horizontal position counts 0..HTOT and then wraps to 0. At each horizontal wrap the vertical position advances and wraps to 0 after VTOT. HTOT and VTOT hold the total minus one.
- R2: The raw horizontal sync is active for positions below HSW. In progressive mode and in even fields, the raw vertical sync is active for lines below VSW.
- R3: Each polarity bit selects the sync sense at the pin. A value of 0 gives an active-high pulse and 1 gives an active-low pulse.
- R4: Horizontal blank is low only when HBE <= position < HBS, and vertical blank likewise uses VBE and VBS. Data-enable is high only when the block runs and neither blank is set.
- R5: With forced blank set, the pixel output equals the stored colour. The colour is packed B/Cb in bits 7:0, G/Y in 15:8 and R/Cr in 23:16. Otherwise the pixel output equals the pixel input.
- R6: The frame count increments by one when the vertical position steps onto VBS, and at no other time.
- R7: Clearing enable freezes both positions and the frame count, and forces data-enable low.
- R8: While running, writes to the timing registers, the polarity bits and the interlace bit take effect at the next frame wrap. While stopped, they take effect one cycle after the write. Enable, forced blank and the colour take effect on the write edge.
- R9: With interlace active, the field flag toggles at every frame wrap, and is 0 otherwise. In odd fields, vertical sync runs from position (H/2, 0) up to, but not including, (H/2, VSW), where H/2 = (HTOT+1)/2.
- R10: The register map is: 0 HTOT, 1 VTOT, 2 HSW, 3 VSW, 4 HBE, 5 HBS, 6 VBE, 7 VBS, 8 control and 9 colour. Control bits are enable (bit 0), horizontal polarity (bit 1), vertical polarity (bit 2), interlace (bit 3) and forced blank (bit 4). Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 24 | Register write data |
| pix_in | input | 24 | Incoming pixel |
| pix_out | output | 24 | Pixel after the blank-colour mux |
| hsync | output | 1 | Horizontal sync at the pin polarity |
| vsync | output | 1 | Vertical sync at the pin polarity |
| hblank | output | 1 | Horizontal blank flag |
| vblank | output | 1 | Vertical blank status |
| de | output | 1 | Data enable |
| field | output | 1 | Interlace field flag, 1 for the odd field |
| hpos | output | 12 | Horizontal position |
| vpos | output | 12 | Vertical position |
| frame_cnt | output | 16 | Frame count |

## Verification
The assertions check four rules on every cycle:
- both counters wrap at their programmed totals;
- nothing moves while the block is stopped;
- the frame count never steps by more than one;
- the active timing set holds still between frame wraps while the block runs.

Only the bench scenarios can show the rest:
- the exact sync and blank windows, and sync polarity;
- the half-line shift of vertical sync in odd fields;
- the deferred effect of a mid-frame write;
- the colour substitution and the ignored unmapped writes.

The bench compares these against a cycle model built from the requirements.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int COMP_W   = 8;
  parameter int NUM_TREG = 8;
  parameter int ADDR_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_HTOT  = 4'd0,
    RA_VTOT  = 4'd1,
    RA_HSW   = 4'd2,
    RA_VSW   = 4'd3,
    RA_HBE   = 4'd4,
    RA_HBS   = 4'd5,
    RA_VBE   = 4'd6,
    RA_VBS   = 4'd7,
    RA_CTRL  = 4'd8,
    RA_COLOR = 4'd9
  } rtg_addr_e;

  localparam int CB_EN     = 0;
  localparam int CB_HPOL   = 1;
  localparam int CB_VPOL   = 2;
  localparam int CB_ILACE  = 3;
  localparam int CB_FBLANK = 4;

  typedef struct packed {
    logic [COMP_W-1:0] rcr;
    logic [COMP_W-1:0] gy;
    logic [COMP_W-1:0] bcb;
  } rtg_color_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DW-1:0]                wdata,
  input  logic                         frame_wrap,
  output logic [NUM_TREG-1:0][CW-1:0]  act,
  output logic                         act_hpol,
  output logic                         act_vpol,
  output logic                         act_ilace,
  output logic                         en,
  output logic                         fblank,
  output rtg_color_t                   color
);
  localparam int IW = $clog2(NUM_TREG);
  localparam int PW = 3 * COMP_W;

  logic [NUM_TREG-1:0][CW-1:0] pend;
  logic p_hpol, p_vpol, p_ilace;
  logic load;

  // Staged timing registers, one write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (we && (int'(addr) < NUM_TREG)) begin
      pend[addr[IW-1:0]] <= wdata[CW-1:0];
    end
  end

  // Control and colour: enable, blank force and colour are immediate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      fblank  <= 1'b0;
      p_hpol  <= 1'b0;
      p_vpol  <= 1'b0;
      p_ilace <= 1'b0;
      color   <= '0;
    end else if (we) begin
      if (addr == RA_CTRL) begin
        en      <= wdata[CB_EN];
        fblank  <= wdata[CB_FBLANK];
        p_hpol  <= wdata[CB_HPOL];
        p_vpol  <= wdata[CB_VPOL];
        p_ilace <= wdata[CB_ILACE];
      end
      if (addr == RA_COLOR) begin
        color <= rtg_color_t'(wdata[PW-1:0]);
      end
    end
  end

  // Active set: copied at a frame wrap, or continuously while stopped
  assign load = !en || frame_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= '0;
      act_hpol  <= 1'b0;
      act_vpol  <= 1'b0;
      act_ilace <= 1'b0;
    end else if (load) begin
      act       <= pend;
      act_hpol  <= p_hpol;
      act_vpol  <= p_vpol;
      act_ilace <= p_ilace;
    end
  end

  // R8: active timing holds between frame wraps while running
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_wrap) |=> ($stable(act) && $stable(act_ilace) && $stable(act_hpol)));
endmodule

// File: rtl/rtg_raster.sv
module rtg_raster #(
  parameter int CW = 12,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  input  logic [CW-1:0] vbs,
  input  logic          ilace,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic [FW-1:0] frame_cnt,
  output logic          field,
  output logic          frame_wrap
);
  logic          hwrap;
  logic [CW-1:0] vnext;

  assign hwrap      = en && (hcnt == htot);
  assign frame_wrap = hwrap && (vcnt == vtot);
  assign vnext      = (vcnt == vtot) ? '0 : vcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt      <= '0;
      vcnt      <= '0;
      frame_cnt <= '0;
      field     <= 1'b0;
    end else begin
      if (en) begin
        hcnt <= hwrap ? '0 : hcnt + 1'b1;
        if (hwrap) begin
          vcnt <= vnext;
          if (vnext == vbs) frame_cnt <= frame_cnt + 1'b1;
        end
      end
      field <= ilace ? (field ^ frame_wrap) : 1'b0;
    end
  end

  // R1: horizontal wrap
  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hcnt == htot) |=> (hcnt == '0));
  // R1: vertical wrap
  a_r1_v_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hcnt == htot && vcnt == vtot) |=> (vcnt == '0));
  // R7: frozen while stopped
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hcnt) && $stable(vcnt) && $stable(frame_cnt)));
  // R6: frame count steps by at most one
  a_r6_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((frame_cnt == $past(frame_cnt)) || (frame_cnt == FW'($past(frame_cnt) + 1'b1))));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode #(
  parameter int CW = 12
) (
  input  logic          en,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic          field,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] hsw,
  input  logic [CW-1:0] vsw,
  input  logic [CW-1:0] hbe,
  input  logic [CW-1:0] hbs,
  input  logic [CW-1:0] vbe,
  input  logic [CW-1:0] vbs,
  input  logic          hpol,
  input  logic          vpol,
  input  logic          ilace,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          de
);
  localparam int NAX = 2;

  logic [NAX-1:0][CW-1:0] pos, bend, bstart;
  logic [NAX-1:0]         blank;
  logic [CW-1:0]          half;
  logic                   vs_even, vs_odd;

  assign pos    = {vcnt, hcnt};
  assign bend   = {vbe, hbe};
  assign bstart = {vbs, hbs};

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    assign blank[a] = !((pos[a] >= bend[a]) && (pos[a] < bstart[a]));
  end

  assign hblank = blank[0];
  assign vblank = blank[1];
  assign de     = en && !blank[0] && !blank[1];

  // Half line for odd-field vertical sync
  assign half = {1'b0, htot[CW-1:1]} + {{(CW-1){1'b0}}, htot[0]};

  assign vs_even = vcnt < vsw;
  assign vs_odd  = ((vcnt != '0) || (hcnt >= half)) &&
                   ((vcnt < vsw) || ((vcnt == vsw) && (hcnt < half)));

  assign hsync = (hcnt < hsw) ^ hpol;
  assign vsync = ((ilace && field) ? vs_odd : vs_even) ^ vpol;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int FW = 16,
  parameter int DW = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  input  logic [3*COMP_W-1:0]   pix_in,
  output logic [3*COMP_W-1:0]   pix_out,
  output logic                  hsync,
  output logic                  vsync,
  output logic                  hblank,
  output logic                  vblank,
  output logic                  de,
  output logic                  field,
  output logic [CW-1:0]         hpos,
  output logic [CW-1:0]         vpos,
  output logic [FW-1:0]         frame_cnt
);
  localparam int T_HTOT = 0, T_VTOT = 1, T_HSW = 2, T_VSW = 3;
  localparam int T_HBE  = 4, T_HBS  = 5, T_VBE = 6, T_VBS = 7;

  logic [NUM_TREG-1:0][CW-1:0] act;
  logic act_hpol, act_vpol, act_ilace, en, fblank, frame_wrap;
  rtg_color_t color;

  rtg_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_wrap(frame_wrap), .act(act), .act_hpol(act_hpol), .act_vpol(act_vpol),
    .act_ilace(act_ilace), .en(en), .fblank(fblank), .color(color)
  );

  rtg_raster #(.CW(CW), .FW(FW)) u_raster (
    .clk(clk), .rst_n(rst_n), .en(en), .htot(act[T_HTOT]), .vtot(act[T_VTOT]),
    .vbs(act[T_VBS]), .ilace(act_ilace), .hcnt(hpos), .vcnt(vpos),
    .frame_cnt(frame_cnt), .field(field), .frame_wrap(frame_wrap)
  );

  rtg_decode #(.CW(CW)) u_decode (
    .en(en), .hcnt(hpos), .vcnt(vpos), .field(field), .htot(act[T_HTOT]),
    .hsw(act[T_HSW]), .vsw(act[T_VSW]), .hbe(act[T_HBE]), .hbs(act[T_HBS]),
    .vbe(act[T_VBE]), .vbs(act[T_VBS]), .hpol(act_hpol), .vpol(act_vpol),
    .ilace(act_ilace), .hsync(hsync), .vsync(vsync), .hblank(hblank),
    .vblank(vblank), .de(de)
  );

  assign pix_out = fblank ? color : pix_in;
endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] pix_in = '0;
  logic [23:0] pix_out;
  logic hsync, vsync, hblank, vblank, de, field;
  logic [11:0] hpos, vpos;
  logic [15:0] frame_cnt;

  always #2 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_in(pix_in), .pix_out(pix_out), .hsync(hsync),
    .vsync(vsync), .hblank(hblank), .vblank(vblank), .de(de), .field(field),
    .hpos(hpos), .vpos(vpos), .frame_cnt(frame_cnt)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic cmp(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  typedef struct {
    logic [11:0] h, v;
    logic hs, vs, hb, vb, de, fld, fb;
    logic [15:0] fr;
    logic [23:0] col;
  } exp_t;
  exp_t q[$];
  exp_t e;

  logic [11:0] mp [8];
  logic [11:0] ma [8];
  logic m_php, m_pvp, m_pil, m_ahp, m_avp, m_ail, m_en, m_fb, m_fld;
  logic [23:0] m_col;
  logic [11:0] m_h, m_v;
  logic [15:0] m_fr;

  always @(posedge clk) begin : model
    logic [11:0] nh, nv, vn, half;
    logic [15:0] nfr;
    logic nfld, hw, fw, vse, vso;
    exp_t x;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin mp[i] = '0; ma[i] = '0; end
      {m_php, m_pvp, m_pil, m_ahp, m_avp, m_ail, m_en, m_fb, m_fld} = '0;
      m_col = '0; m_h = '0; m_v = '0; m_fr = '0;
    end else begin
      hw = m_en && (m_h == ma[0]);
      fw = hw && (m_v == ma[1]);
      vn = (m_v == ma[1]) ? 12'd0 : m_v + 12'd1;
      nh = m_h; nv = m_v; nfr = m_fr;
      if (m_en) begin
        nh = hw ? 12'd0 : m_h + 12'd1;
        if (hw) begin
          nv = vn;
          if (vn == ma[7]) nfr = m_fr + 16'd1;
        end
      end
      nfld = m_ail ? (m_fld ^ fw) : 1'b0;
      if (!m_en || fw) begin
        for (int i = 0; i < 8; i++) ma[i] = mp[i];
        m_ahp = m_php; m_avp = m_pvp; m_ail = m_pil;
      end
      m_h = nh; m_v = nv; m_fr = nfr; m_fld = nfld;
      if (cfg_we) begin
        if (cfg_addr < 4'd8) mp[cfg_addr[2:0]] = cfg_wdata[11:0];
        else if (cfg_addr == 4'd8) begin
          m_en = cfg_wdata[0]; m_php = cfg_wdata[1]; m_pvp = cfg_wdata[2];
          m_pil = cfg_wdata[3]; m_fb = cfg_wdata[4];
        end else if (cfg_addr == 4'd9) m_col = cfg_wdata;
      end
    end
    half = 12'((13'(ma[0]) + 13'd1) >> 1);
    vse = m_v < ma[3];
    vso = ((m_v != 0) || (m_h >= half)) && ((m_v < ma[3]) || ((m_v == ma[3]) && (m_h < half)));
    x.h = m_h; x.v = m_v;
    x.hs = (m_h < ma[2]) ^ m_ahp;
    x.vs = ((m_ail && m_fld) ? vso : vse) ^ m_avp;
    x.hb = !((m_h >= ma[4]) && (m_h < ma[5]));
    x.vb = !((m_v >= ma[6]) && (m_v < ma[7]));
    x.de = m_en && !x.hb && !x.vb;
    x.fr = m_fr; x.fld = m_fld; x.fb = m_fb; x.col = m_col;
    q.push_back(x);
  end

  // Monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp("R1", "hpos", 32'(hpos), 32'(e.h));
      cmp("R1", "vpos", 32'(vpos), 32'(e.v));
      cmp("R2", "hsync", 32'(hsync), 32'(e.hs));
      cmp("R2", "vsync", 32'(vsync), 32'(e.vs));
      cmp("R4", "hblank", 32'(hblank), 32'(e.hb));
      cmp("R4", "vblank", 32'(vblank), 32'(e.vb));
      cmp("R4", "de", 32'(de), 32'(e.de));
      cmp("R6", "frame_cnt", 32'(frame_cnt), 32'(e.fr));
      cmp("R9", "field", 32'(field), 32'(e.fld));
      cmp("R5", "pix_out", 32'(pix_out), 32'(e.fb ? e.col : pix_in));
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 pix_in <= pix_in + 24'h010203;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_pos(input logic [11:0] h, input logic [11:0] v);
    do @(negedge clk); while (!(hpos == h && vpos == v));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] f0;
    logic [11:0] p0, p1, mx;
    bit saw;
    repeat (3) @(negedge clk);
    cmp("R1", "reset hpos", 32'(hpos), 0);
    cmp("R1", "reset frame", 32'(frame_cnt), 0);
    cmp("R1", "reset de", 32'(de), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R10 map: 16x10 raster, sync 2/1, active 5..12 and 3..7
    wr(4'd0, 24'd15); wr(4'd1, 24'd9); wr(4'd2, 24'd2); wr(4'd3, 24'd1);
    wr(4'd4, 24'd5);  wr(4'd5, 24'd13); wr(4'd6, 24'd3); wr(4'd7, 24'd8);
    wr(4'd9, 24'hA1B2C3);
    wr(4'd8, 24'h01);
    repeat (400) @(negedge clk);

    // R6 frame count steps on entry to vertical blank
    wait_pos(12'd0, 12'd7); f0 = frame_cnt;
    wait_pos(12'd0, 12'd8);
    cmp("R6", "frame step", 32'(frame_cnt), 32'(f0 + 16'd1));
    cmp("R6", "vblank status", 32'(vblank), 1);

    // R3 active-low polarity after the next wrap
    wr(4'd8, 24'h07);
    wait_pos(12'd0, 12'd0); wait_pos(12'd0, 12'd0);
    cmp("R3", "hsync low at 0", 32'(hsync), 0);
    cmp("R3", "vsync low at 0", 32'(vsync), 0);
    wait_pos(12'd2, 12'd0);
    cmp("R3", "hsync idle high", 32'(hsync), 1);

    // R5 forced blank colour, R10 unmapped write ignored
    wr(4'd8, 24'h11);
    @(negedge clk);
    cmp("R5", "blank colour", 32'(pix_out), 32'h00A1B2C3);
    wr(4'd10, 24'hFFFFFF);
    wr(4'd15, 24'h000000);
    repeat (2) @(negedge clk);
    cmp("R10", "unmapped write", 32'(pix_out), 32'h00A1B2C3);
    wr(4'd8, 24'h01);
    @(negedge clk);
    cmp("R5", "pass through", 32'(pix_out), 32'(pix_in));

    // R8 mid-frame total change deferred to the wrap
    wait_pos(12'd3, 12'd3);
    wr(4'd0, 24'd11); wr(4'd5, 24'd9);
    saw = 0;
    repeat (20) begin @(negedge clk); if (hpos == 12'd15) saw = 1; end
    cmp("R8", "old total in use", 32'(saw), 1);
    wait_pos(12'd0, 12'd0);
    mx = 0;
    repeat (130) begin @(negedge clk); if (hpos > mx) mx = hpos; end
    cmp("R8", "new total", 32'(mx), 11);

    // R7 stop freezes position
    wr(4'd8, 24'h00);
    @(negedge clk); p0 = hpos; p1 = vpos;
    repeat (10) @(negedge clk);
    cmp("R7", "hpos frozen", 32'(hpos), 32'(p0));
    cmp("R7", "vpos frozen", 32'(vpos), 32'(p1));
    cmp("R7", "de low", 32'(de), 0);
    wr(4'd0, 24'd15); wr(4'd5, 24'd13);

    // R9 interlace: field toggles, odd field vsync shifted by 8
    wr(4'd8, 24'h09);
    wait_pos(12'd0, 12'd0); wait_pos(12'd0, 12'd0);
    cmp("R9", "odd field", 32'(field), 1);
    cmp("R9", "odd vsync idle at 0", 32'(vsync), 0);
    wait_pos(12'd8, 12'd0);
    cmp("R9", "odd vsync half line", 32'(vsync), 1);
    wait_pos(12'd8, 12'd1);
    cmp("R9", "odd vsync end", 32'(vsync), 0);
    wait_pos(12'd0, 12'd0);
    cmp("R9", "even field", 32'(field), 0);
    cmp("R2", "even vsync at 0", 32'(vsync), 1);
    repeat (200) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule